// File: doc/BRIEF.md
# Chip Reset Sequencer with Shared Stretch Timer

This block generates the single active-low reset for a chip. It runs from an always-on slow clock. It combines three reset causes: the raw power-good indication from the supply monitor, an active-low external reset pin, and a trip request from the watchdog. It drives one reset line to the rest of the chip. The block also exposes a flag that lets software tell a cold start from a warm restart.

The design has two stages. On a cold start, a power-up delay counter must expire first, and it runs only after power-good returns. Every cause then passes through one shared stretch timer. This includes the end of the power-up delay, a qualified pin request and a watchdog trip. The stretch length is two to the power of a stage-count parameter, so removing one stage halves it. A warm restart therefore costs only the stretch time, and a cold start costs the power-up delay plus the stretch time.

The stretch time also sets the shortest useful watchdog timeout. For that reason it is kept short by default. The watchdog trip is assumed to come from logic already clocked by the slow clock. The pin is asynchronous and is synchronized inside the block.

Top module: `rst_seq_ctrl`

## Requirements
- R1: After `pwr_ok` rises, `chip_rst_n` goes high exactly `PUP_CYCLES + 2**EXT_STAGES` rising clock edges later. This is the cold reset length.
- R2: `chip_rst_n` is never high while the power-up delay is still running, that is, while `cold_start` is 0.
- R3: A watchdog trip asserts reset on the first rising edge that samples `wdog_trip` high. Reset is held while the trip stays high.
- R4: The stretch timer releases reset exactly `2**EXT_STAGES` rising edges after the last edge that saw any reset cause. Watchdog and pin restarts skip the power-up delay.
- R5: A new reset cause that arrives while the stretch timer is counting restarts the count from zero. Release then follows `2**EXT_STAGES` edges after that new cause ends.
- R6: `ext_rst_n` passes through a two-flop synchronizer. It counts as a request only after it has been low for `PIN_MIN_LOW` consecutive samples. Reset then asserts on rising edge `PIN_MIN_LOW + 3` after the pin falls, and shorter low pulses leave `chip_rst_n` high.
- R7: After the pin returns high, reset releases on rising edge `3 + 2**EXT_STAGES`, counted from the first edge that samples the pin high.
- R8: `cold_start` goes high on the same edge that ends the power-up delay, exactly `PUP_CYCLES` edges after `pwr_ok` rises. It stays high through every warm restart.
- R9: When `pwr_ok` falls, `chip_rst_n` and `cold_start` go low at once, without waiting for a clock edge. Both counters clear, so the next rise of `pwr_ok` starts a full cold sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Always-on slow clock |
| pwr_ok | input | 1 | Raw power-good; low clears the block asynchronously |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wdog_trip | input | 1 | Watchdog trip request, synchronous to `clk_slow` |
| chip_rst_n | output | 1 | Chip reset, active low |
| cold_start | output | 1 | High once the power-up delay has completed since power-good rose |

## Verification
The embedded properties check the following on every cycle:
- the stretch timer holds reset while any cause is present and restarts its count;
- release happens only after a full count;
- the power-up delay ends at its exact count, and its flag stays set;
- the pin request rises only after a low synchronized sample and clears once the pin is high;
- reset stays asserted while power-good is low or the delay is still running.

Exact end-to-end latencies need the bench's scenarios. These are the cold length, the pin qualification threshold at its boundary, restart in the middle of a count, and the asynchronous drop on power loss between clock edges. The bench's scenarios also show that the cold flag survives warm restarts.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    // One bit per reset cause feeding the shared stretch timer.
    typedef struct packed {
        logic power_up;   // power-up delay still running
        logic pin;        // qualified external pin request
        logic wdog;       // watchdog trip
    } rsq_src_t;

    function automatic logic src_any(input rsq_src_t s);
        return s.power_up | s.pin | s.wdog;
    endfunction

    // Length of a stretch chain with the given number of doubling stages.
    function automatic int unsigned stretch_cycles(input int unsigned stages);
        return 32'd1 << stages;
    endfunction

endpackage

// File: rtl/rsq_pin_filter.sv
module rsq_pin_filter #(
    parameter int unsigned SYNC_DEPTH = 2,
    parameter int unsigned MIN_LOW    = 4
) (
    input  logic clk,
    input  logic pwr_ok,
    input  logic pin_n,
    output logic req
);
    localparam int unsigned CW = $clog2(MIN_LOW + 1);
    localparam logic [CW-1:0] LIM = CW'(MIN_LOW);

    logic [SYNC_DEPTH-1:0] sync_q;
    logic                  pin_s;
    logic [CW-1:0]         low_cnt;

    // Synchronizer, cleared to the released (high) level.
    always_ff @(posedge clk or negedge pwr_ok) begin
        if (!pwr_ok) sync_q <= '1;
        else         sync_q <= {sync_q[SYNC_DEPTH-2:0], pin_n};
    end

    assign pin_s = sync_q[SYNC_DEPTH-1];

    // Saturating count of consecutive low samples.
    always_ff @(posedge clk or negedge pwr_ok) begin
        if (!pwr_ok)              low_cnt <= '0;
        else if (pin_s)           low_cnt <= '0;
        else if (low_cnt != LIM)  low_cnt <= low_cnt + 1'b1;
    end

    assign req = (low_cnt == LIM);

    a_r6_req_after_low: assert property (@(posedge clk) disable iff (!pwr_ok)
        $rose(req) |-> !$past(pin_s));

    a_r7_req_drops_on_high: assert property (@(posedge clk) disable iff (!pwr_ok)
        pin_s |=> !req);

endmodule

// File: rtl/rsq_powerup_timer.sv
module rsq_powerup_timer #(
    parameter int unsigned PUP_CYCLES = 640
) (
    input  logic clk,
    input  logic pwr_ok,
    output logic done
);
    localparam int unsigned CW = $clog2(PUP_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(PUP_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge pwr_ok) begin
        if (!pwr_ok) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (!done) begin
            if (cnt == LAST) done <= 1'b1;
            else             cnt  <= cnt + 1'b1;
        end
    end

    a_r1_done_at_full_count: assert property (@(posedge clk) disable iff (!pwr_ok)
        $rose(done) |-> ($past(cnt) == LAST));

    a_r8_done_sticky: assert property (@(posedge clk) disable iff (!pwr_ok)
        $past(done) |-> done);

endmodule

// File: rtl/rsq_extender.sv
module rsq_extender #(
    parameter int unsigned STAGES = 7
) (
    input  logic clk,
    input  logic pwr_ok,
    input  logic req,
    output logic active
);
    import rsq_pkg::*;

    localparam int unsigned LEN = stretch_cycles(STAGES);
    localparam logic [STAGES-1:0] LAST = STAGES'(LEN - 1);

    logic [STAGES-1:0] cnt;

    always_ff @(posedge clk or negedge pwr_ok) begin
        if (!pwr_ok) begin
            cnt    <= '0;
            active <= 1'b1;
        end else if (req) begin
            cnt    <= '0;
            active <= 1'b1;
        end else if (active) begin
            if (cnt == LAST) active <= 1'b0;
            cnt <= cnt + 1'b1;
        end
    end

    a_r3_cause_holds_reset: assert property (@(posedge clk) disable iff (!pwr_ok)
        req |=> active);

    a_r5_cause_restarts_count: assert property (@(posedge clk) disable iff (!pwr_ok)
        req |=> (cnt == '0));

    a_r4_release_after_full_count: assert property (@(posedge clk) disable iff (!pwr_ok)
        $fell(active) |-> (($past(cnt) == LAST) && !$past(req)));

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl #(
    parameter int unsigned PUP_CYCLES  = 640,
    parameter int unsigned EXT_STAGES  = 7,
    parameter int unsigned PIN_MIN_LOW = 4,
    parameter int unsigned SYNC_DEPTH  = 2
) (
    input  logic clk_slow,
    input  logic pwr_ok,
    input  logic ext_rst_n,
    input  logic wdog_trip,
    output logic chip_rst_n,
    output logic cold_start
);
    import rsq_pkg::*;

    rsq_src_t src;
    logic     pup_done;
    logic     pin_req;
    logic     stretch_active;

    rsq_powerup_timer #(.PUP_CYCLES(PUP_CYCLES)) u_pup (
        .clk    (clk_slow),
        .pwr_ok (pwr_ok),
        .done   (pup_done)
    );

    rsq_pin_filter #(.SYNC_DEPTH(SYNC_DEPTH), .MIN_LOW(PIN_MIN_LOW)) u_pin (
        .clk    (clk_slow),
        .pwr_ok (pwr_ok),
        .pin_n  (ext_rst_n),
        .req    (pin_req)
    );

    always_comb begin
        src.power_up = !pup_done;
        src.pin      = pin_req;
        src.wdog     = wdog_trip;
    end

    rsq_extender #(.STAGES(EXT_STAGES)) u_ext (
        .clk    (clk_slow),
        .pwr_ok (pwr_ok),
        .req    (src_any(src)),
        .active (stretch_active)
    );

    assign chip_rst_n = !stretch_active;
    assign cold_start = pup_done;

    a_r2_release_needs_delay_done: assert property (@(posedge clk_slow) disable iff (!pwr_ok)
        chip_rst_n |-> cold_start);

    a_r9_power_loss_holds_reset: assert property (@(posedge clk_slow)
        !pwr_ok |-> (!chip_rst_n && !cold_start));

endmodule

// File: tb/sim_rst_seq_ctrl.sv
module sim_rst_seq_ctrl;
    localparam int PUP  = 16;
    localparam int EXTS = 3;
    localparam int EXT  = 8;
    localparam int PMIN = 4;

    logic clk = 1'b0;
    logic pwr_ok = 1'b1;
    logic ext_rst_n = 1'b1;
    logic wdog_trip = 1'b0;
    logic chip_rst_n;
    logic cold_start;
    int   checks = 0;
    int   failures = 0;

    always #4 clk = ~clk;

    rst_seq_ctrl #(.PUP_CYCLES(PUP), .EXT_STAGES(EXTS), .PIN_MIN_LOW(PMIN), .SYNC_DEPTH(2)) u0 (
        .clk_slow   (clk),
        .pwr_ok     (pwr_ok),
        .ext_rst_n  (ext_rst_n),
        .wdog_trip  (wdog_trip),
        .chip_rst_n (chip_rst_n),
        .cold_start (cold_start)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_wdog_lows(input int len, input int s2);
        int last = (s2 > 0) ? s2 + len - 1 : len - 1;
        return last + EXT;
    endfunction

    function automatic int exp_pin_lows(input int len);
        return (len >= PMIN) ? len - PMIN + EXT : 0;
    endfunction

    // Called at a negedge with pwr_ok low; raises it and times the cold sequence.
    task automatic cold_boot(input string tag);
        int first_cold = -1;
        int first_rel = -1;
        bit early = 0;
        pwr_ok = 1'b1;
        for (int k = 1; k <= PUP + EXT + 6; k++) begin
            @(negedge clk);
            if (first_cold < 0 && cold_start) first_cold = k;
            if (first_rel < 0 && chip_rst_n) first_rel = k;
            if (chip_rst_n && !cold_start) early = 1;
        end
        check(first_cold == PUP, {"R8 cold flag timing ", tag}, first_cold, PUP);
        check(first_rel == PUP + EXT, {"R1 cold release timing ", tag}, first_rel, PUP + EXT);
        check(!early, {"R2 release before delay end ", tag}, int'(early), 0);
    endtask

    // Drives one or two pulses on the pin or watchdog and counts low samples.
    task automatic pulse(input bit use_pin, input int len, input int s2, input int window,
                         output int lows);
        lows = 0;
        for (int i = 0; i < window; i++) begin
            @(negedge clk);
            if (i > 0 && !chip_rst_n) lows++;
            if (use_pin) ext_rst_n = !((i < len) || (s2 > 0 && i >= s2 && i < s2 + len));
            else         wdog_trip =  ((i < len) || (s2 > 0 && i >= s2 && i < s2 + len));
        end
        ext_rst_n = 1'b1;
        wdog_trip = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int lows;
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        #1 pwr_ok = 1'b0;
        @(negedge clk);
        check(chip_rst_n == 1'b0, "R9 reset state chip_rst_n", int'(chip_rst_n), 0);
        check(cold_start == 1'b0, "R9 reset state cold_start", int'(cold_start), 0);
        cold_boot("first");

        // R3/R4: single watchdog trip, warm restart of stretch length only
        pulse(1'b0, 1, 0, EXT + 8, lows);
        check(lows == exp_wdog_lows(1, 0), "R3 R4 wdog one-cycle trip", lows, exp_wdog_lows(1, 0));
        check(chip_rst_n == 1'b1, "R4 released after wdog", int'(chip_rst_n), 1);
        check(cold_start == 1'b1, "R8 cold flag after warm restart", int'(cold_start), 1);

        // R3: held trip keeps reset asserted
        pulse(1'b0, 5, 0, 5 + EXT + 8, lows);
        check(lows == exp_wdog_lows(5, 0), "R3 wdog held five cycles", lows, exp_wdog_lows(5, 0));

        // R5: second trip in the middle of the count restarts it
        pulse(1'b0, 1, EXT / 2, EXT + EXT + 8, lows);
        check(lows == exp_wdog_lows(1, EXT / 2), "R5 restart mid count", lows, exp_wdog_lows(1, EXT / 2));

        // R6: pin one sample short of the threshold is ignored
        pulse(1'b1, PMIN - 1, 0, PMIN + EXT + 8, lows);
        check(lows == 0, "R6 short pin pulse ignored", lows, 0);
        // R6/R7: pin exactly at the threshold
        pulse(1'b1, PMIN, 0, PMIN + EXT + 8, lows);
        check(lows == exp_pin_lows(PMIN), "R6 R7 pin at threshold", lows, exp_pin_lows(PMIN));
        pulse(1'b1, PMIN + 6, 0, PMIN + 6 + EXT + 8, lows);
        check(lows == exp_pin_lows(PMIN + 6), "R7 long pin pulse", lows, exp_pin_lows(PMIN + 6));
        check(cold_start == 1'b1, "R8 cold flag after pin restart", int'(cold_start), 1);

        // Random mix of watchdog and pin restarts
        for (int n = 0; n < 16; n++) begin
            bit use_pin = bit'($urandom % 2);
            int len = use_pin ? 1 + int'($urandom % (PMIN + 6)) : 1 + int'($urandom % 4);
            int exp = use_pin ? exp_pin_lows(len) : exp_wdog_lows(len, 0);
            pulse(use_pin, len, 0, len + EXT + 8, lows);
            check(lows == exp, use_pin ? "R6 R7 random pin" : "R3 R4 random wdog", lows, exp);
            check(chip_rst_n == 1'b1, "R4 random released", int'(chip_rst_n), 1);
        end

        // R9: power loss between edges, in the middle of a stretch count
        @(negedge clk);
        wdog_trip = 1'b1;
        @(negedge clk);
        wdog_trip = 1'b0;
        repeat (2) @(negedge clk);
        #2 pwr_ok = 1'b0;
        #1;
        check(chip_rst_n == 1'b0, "R9 async drop chip_rst_n", int'(chip_rst_n), 0);
        check(cold_start == 1'b0, "R9 async drop cold_start", int'(cold_start), 0);
        @(negedge clk);
        cold_boot("after mid-count loss");

        // R9: power loss while running, no clock edge in between
        repeat (3) @(negedge clk);
        #1 pwr_ok = 1'b0;
        #1;
        check(chip_rst_n == 1'b0, "R9 drop while running", int'(chip_rst_n), 0);
        @(negedge clk);
        cold_boot("after running loss");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule